// File: doc/BRIEF.md
# ADC Conversion Sequencing Controller

This block is the digital control core of a 12-bit successive-approximation converter peripheral. It picks one of four trigger inputs (a software start bit or one of three timer outputs), watches the selected signal for rising edges, and produces the sampling-window signal. In pulse mode a programmable sampling timer shapes the window. In direct mode the window follows the trigger level itself. It then hands a start strobe to a conversion engine and, when the engine reports done, issues a one-cycle store strobe naming the result slot and its channel.

Sixteen result slots each carry a channel number and an end-of-list flag. Four sequence modes decide which slot comes next: one slot once, a list of slots once, one slot repeatedly, or a list of slots repeatedly. A chaining option lets a single trigger edge run a whole list or repetition back to back. Without it, every conversion waits for its own edge. Slots in the lower half take their sample length from one code field and slots in the upper half from another. All configuration arrives as plain input ports. The conversion engine is modelled as a start/done handshake of fixed latency.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `trig_sel` picks the trigger: 0 = `sw_start`, 1 = `trig_ta1`, 2 = `trig_tb0`, 3 = `trig_tb1`. Edges on the sources that are not selected never start a conversion.
- R2: A conversion starts only on a rising edge of the selected trigger. When the software source starts one, `sw_start_clr` pulses for one cycle so that the start bit can be cleared.
- R3: No conversion starts unless `conv_on` and `conv_en` are both 1.
- R4: In pulse mode, `samp_win` stays high for exactly L cycles. L comes from the 4-bit code: codes 0..12 give 4, 8, 16, 32, 64, 96, 128, 192, 256, 384, 512, 768 and 1024, and codes 13..15 give 1024. `eng_start` pulses in the cycle right after the window ends.
- R5: Slots 0..7 use `samp_lo_code` and slots 8..15 use `samp_hi_code`.
- R6: In direct mode (`pulse_mode`=0), `samp_win` follows the trigger level while sampling, and `eng_start` pulses in the cycle after the trigger falls. `multi_conv` has no effect in direct mode.
- R7: In mode 00, each edge converts `start_slot` once, and the block then goes idle.
- R8: In mode 01, slots are converted upward from `start_slot`, with 15 wrapping to 0, through the first slot whose `slot_last` bit is set. The next edge after that starts again at `start_slot`.
- R9: In mode 10, every conversion uses `start_slot`.
- R10: In mode 11, slots are stepped as in R8, but after a flagged slot the block returns to `start_slot` and keeps going.
- R11: With `multi_conv`=1 in pulse mode and modes 01, 10 or 11, the next conversion's window begins in the same cycle as the previous store, with no further edge needed. In mode 00 the bit has no effect.
- R12: If `conv_en` is cleared while a conversion is in progress, that conversion completes and is stored. No further conversion follows, and `busy` returns to 0.
- R13: One cycle after `eng_done`, `store_valid` pulses for one cycle with `store_slot` and `store_chan` (that slot's 4-bit channel field in `slot_chan`, bits slot*4 and up). It never coincides with `eng_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | converter clock |
| rst_n | input | 1 | active-low synchronous reset |
| conv_on | input | 1 | converter powered |
| conv_en | input | 1 | conversions enabled |
| sw_start | input | 1 | software start bit |
| trig_ta1 | input | 1 | timer A output 1 |
| trig_tb0 | input | 1 | timer B output 0 |
| trig_tb1 | input | 1 | timer B output 1 |
| trig_sel | input | 2 | trigger source select |
| seq_mode | input | 2 | sequence mode |
| multi_conv | input | 1 | chain conversions after first edge |
| pulse_mode | input | 1 | 1 = timer window, 0 = direct window |
| samp_lo_code | input | 4 | sample-length code, slots 0..7 |
| samp_hi_code | input | 4 | sample-length code, slots 8..15 |
| start_slot | input | 4 | first slot of a sequence |
| slot_chan | input | 64 | packed per-slot channel numbers |
| slot_last | input | 16 | per-slot end-of-list flags |
| eng_done | input | 1 | conversion engine finished |
| sw_start_clr | output | 1 | clear request for sw_start |
| samp_win | output | 1 | sampling window |
| eng_start | output | 1 | start strobe to engine |
| eng_chan | output | 4 | channel of the current slot |
| store_valid | output | 1 | result store strobe |
| store_slot | output | 4 | slot being stored |
| store_chan | output | 4 | channel of stored slot |
| busy | output | 1 | sampling or converting |

## Verification
The assertions check four rules on every cycle: that an idle block with conversions disabled stays idle, that a timed window ends with a start strobe, that every store follows a done from the engine and never coincides with a start, and that a single-conversion completion returns to idle. They also check that the sample counter stays in range and that an edge is reported for every low-to-high step of the selected trigger. The exact window length for every code in both slot halves, and the mapping from trigger source to input, can only be shown by the bench's scenarios. The same holds for the slot orders of the list and repeat modes, for chaining, and for the stop after the enable is cleared.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int SCODE_W = 4;
  localparam int SCNT_W  = 11;

  typedef enum logic [1:0] {
    SEQ_ONCE     = 2'b00,
    SEQ_LIST     = 2'b01,
    SEQ_REP_ONE  = 2'b10,
    SEQ_REP_LIST = 2'b11
  } seq_mode_e;

  typedef enum logic [1:0] {
    TRG_SOFT = 2'b00,
    TRG_TA1  = 2'b01,
    TRG_TB0  = 2'b10,
    TRG_TB1  = 2'b11
  } trig_src_e;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'b00,
    PH_SAMPLE  = 2'b01,
    PH_CONVERT = 2'b10
  } phase_e;

  // Sample length in converter-clock cycles for a 4-bit code.
  function automatic logic [SCNT_W-1:0] samp_len(input logic [SCODE_W-1:0] code);
    logic [SCNT_W-1:0] len;
    case (code)
      4'd0:  len = 11'd4;
      4'd1:  len = 11'd8;
      4'd2:  len = 11'd16;
      4'd3:  len = 11'd32;
      4'd4:  len = 11'd64;
      4'd5:  len = 11'd96;
      4'd6:  len = 11'd128;
      4'd7:  len = 11'd192;
      4'd8:  len = 11'd256;
      4'd9:  len = 11'd384;
      4'd10: len = 11'd512;
      4'd11: len = 11'd768;
      default: len = 11'd1024;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/adc_trig_pick.sv
module adc_trig_pick
  import adc_seq_pkg::*;
#(
  parameter int NSRC = 4,
  localparam int SEL_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [NSRC-1:0]  src,
  output logic             trig_raw,
  output logic             trig_rise
);

  logic prev_q;

  assign trig_raw  = src[sel];
  assign trig_rise = trig_raw & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= trig_raw;
  end

  // R2: a low-to-high step of a stable selection is reported as an edge
  assert_edge_seen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_raw && !$past(trig_raw) && $stable(sel) && $past(rst_n)) |-> trig_rise);

endmodule

// File: rtl/adc_samp_timer.sv
module adc_samp_timer
  import adc_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [SCODE_W-1:0] code,
  input  logic               run,
  output logic               expire
);

  logic [SCNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                         count_q <= '0;
    else if (load)                      count_q <= samp_len(code);
    else if (run && count_q != '0)      count_q <= count_q - 1'b1;
  end

  assign expire = run && (count_q == SCNT_W'(1));

  // R4: the counter never holds more than the longest window
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= SCNT_W'(1024));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NSLOT = 16,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enabled,
  input  logic              trig_rise,
  input  logic              trig_raw,
  input  logic              soft_src,
  input  logic              pulse_mode,
  input  logic              multi_conv,
  input  logic [1:0]        seq_mode,
  input  logic [SLOT_W-1:0] start_slot,
  input  logic [NSLOT-1:0]  slot_last,
  input  logic              timer_expire,
  input  logic              eng_done,
  output phase_e            phase,
  output logic [SLOT_W-1:0] cur_slot,
  output logic [SLOT_W-1:0] load_slot,
  output logic              timer_load,
  output logic              eng_start,
  output logic              store_valid,
  output logic [SLOT_W-1:0] store_slot,
  output logic              sw_clr,
  output logic              samp_win
);

  phase_e            phase_q;
  logic [SLOT_W-1:0] slot_q;
  logic              mid_q;
  logic              pulse_q;

  // named internal events
  logic              accept;
  logic              done_now;
  logic              is_last;
  logic              seq_over;
  logic              chain;
  logic              steps_on;
  logic [SLOT_W-1:0] step_slot;
  logic [SLOT_W-1:0] follow_slot;
  logic [SLOT_W-1:0] launch_slot;
  seq_mode_e         mode;

  assign mode      = seq_mode_e'(seq_mode);
  assign accept    = (phase_q == PH_IDLE) && enabled && trig_rise;
  assign done_now  = (phase_q == PH_CONVERT) && eng_done;
  assign is_last   = slot_last[slot_q];
  assign step_slot = (slot_q == SLOT_W'(NSLOT-1)) ? '0 : slot_q + 1'b1;
  assign launch_slot = mid_q ? slot_q : start_slot;

  always_comb begin
    follow_slot = start_slot;
    seq_over    = 1'b0;
    steps_on    = 1'b0;
    case (mode)
      SEQ_ONCE: begin
        seq_over = 1'b1;
      end
      SEQ_LIST: begin
        seq_over    = is_last;
        steps_on    = !is_last;
        follow_slot = is_last ? start_slot : step_slot;
      end
      SEQ_REP_ONE: begin
        follow_slot = slot_q;
      end
      default: begin
        steps_on    = !is_last;
        follow_slot = is_last ? start_slot : step_slot;
      end
    endcase
  end

  assign chain      = multi_conv && pulse_q && (mode != SEQ_ONCE) && !seq_over && enabled;
  assign timer_load = (accept && pulse_mode) || (done_now && chain);
  assign load_slot  = accept ? launch_slot : follow_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      slot_q      <= '0;
      mid_q       <= 1'b0;
      pulse_q     <= 1'b0;
      eng_start   <= 1'b0;
      store_valid <= 1'b0;
      store_slot  <= '0;
      sw_clr      <= 1'b0;
    end else begin
      eng_start   <= 1'b0;
      store_valid <= 1'b0;
      sw_clr      <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (!enabled) mid_q <= 1'b0;
          if (accept) begin
            slot_q  <= launch_slot;
            pulse_q <= pulse_mode;
            sw_clr  <= soft_src;
            phase_q <= PH_SAMPLE;
          end
        end
        PH_SAMPLE: begin
          if (pulse_q ? timer_expire : !trig_raw) begin
            eng_start <= 1'b1;
            phase_q   <= PH_CONVERT;
          end
        end
        PH_CONVERT: begin
          if (eng_done) begin
            store_valid <= 1'b1;
            store_slot  <= slot_q;
            if (!enabled || seq_over) begin
              mid_q   <= 1'b0;
              phase_q <= PH_IDLE;
            end else begin
              mid_q   <= steps_on;
              slot_q  <= follow_slot;
              phase_q <= chain ? PH_SAMPLE : PH_IDLE;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase    = phase_q;
  assign cur_slot = slot_q;
  assign samp_win = (phase_q == PH_SAMPLE) && (pulse_q || trig_raw);

  // R3: an idle, disabled block stays idle
  assert_gate_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && !enabled) |=> (phase_q == PH_IDLE));

  // R4: a timed window ends with a start strobe
  assert_win_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && $fell(samp_win)) |-> eng_start);

  // R13: a store always follows a done seen while converting
  assert_store_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
    store_valid |-> ($past(eng_done) && $past(phase_q) == PH_CONVERT));

  // R13: start and store strobes never coincide
  assert_no_overlap_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_start, store_valid}));

  // R7: single-conversion mode goes idle after the store
  assert_once_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_now && mode == SEQ_ONCE) |=> (phase_q == PH_IDLE));

  // R2: the clear request follows an accepted edge
  assert_clr_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |-> ($past(trig_rise) && $past(soft_src)));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int CH_W  = 4,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int HALF   = NSLOT / 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  conv_on,
  input  logic                  conv_en,
  input  logic                  sw_start,
  input  logic                  trig_ta1,
  input  logic                  trig_tb0,
  input  logic                  trig_tb1,
  input  logic [1:0]            trig_sel,
  input  logic [1:0]            seq_mode,
  input  logic                  multi_conv,
  input  logic                  pulse_mode,
  input  logic [SCODE_W-1:0]    samp_lo_code,
  input  logic [SCODE_W-1:0]    samp_hi_code,
  input  logic [SLOT_W-1:0]     start_slot,
  input  logic [NSLOT*CH_W-1:0] slot_chan,
  input  logic [NSLOT-1:0]      slot_last,
  input  logic                  eng_done,
  output logic                  sw_start_clr,
  output logic                  samp_win,
  output logic                  eng_start,
  output logic [CH_W-1:0]       eng_chan,
  output logic                  store_valid,
  output logic [SLOT_W-1:0]     store_slot,
  output logic [CH_W-1:0]       store_chan,
  output logic                  busy
);

  logic              enabled;
  logic              trig_raw;
  logic              trig_rise;
  logic              soft_src;
  logic              timer_load;
  logic              timer_expire;
  logic              run;
  logic [SLOT_W-1:0] cur_slot;
  logic [SLOT_W-1:0] load_slot;
  logic [SCODE_W-1:0] load_code;
  phase_e            phase;
  logic [CH_W-1:0]   chan_tbl [NSLOT];

  assign enabled  = conv_on & conv_en;
  assign soft_src = (trig_src_e'(trig_sel) == TRG_SOFT);

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_chan
      assign chan_tbl[g] = slot_chan[g*CH_W +: CH_W];
    end
  endgenerate

  adc_trig_pick #(.NSRC(4)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (trig_sel),
    .src       ({trig_tb1, trig_tb0, trig_ta1, sw_start}),
    .trig_raw  (trig_raw),
    .trig_rise (trig_rise)
  );

  assign load_code = (int'(load_slot) >= HALF) ? samp_hi_code : samp_lo_code;
  assign run       = (phase == PH_SAMPLE);

  adc_samp_timer u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (timer_load),
    .code   (load_code),
    .run    (run),
    .expire (timer_expire)
  );

  adc_seq_fsm #(.NSLOT(NSLOT)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .enabled      (enabled),
    .trig_rise    (trig_rise),
    .trig_raw     (trig_raw),
    .soft_src     (soft_src),
    .pulse_mode   (pulse_mode),
    .multi_conv   (multi_conv),
    .seq_mode     (seq_mode),
    .start_slot   (start_slot),
    .slot_last    (slot_last),
    .timer_expire (timer_expire),
    .eng_done     (eng_done),
    .phase        (phase),
    .cur_slot     (cur_slot),
    .load_slot    (load_slot),
    .timer_load   (timer_load),
    .eng_start    (eng_start),
    .store_valid  (store_valid),
    .store_slot   (store_slot),
    .sw_clr       (sw_start_clr),
    .samp_win     (samp_win)
  );

  assign eng_chan   = chan_tbl[cur_slot];
  assign store_chan = chan_tbl[store_slot];
  assign busy       = (phase != PH_IDLE);

endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;

  logic clk = 0;
  logic rst_n = 0;
  logic conv_on = 0, conv_en = 0, sw_start = 0;
  logic trig_ta1 = 0, trig_tb0 = 0, trig_tb1 = 0;
  logic [1:0] trig_sel = 0, seq_mode = 0;
  logic multi_conv = 0, pulse_mode = 1;
  logic [3:0] samp_lo_code = 0, samp_hi_code = 0, start_slot = 0;
  logic [63:0] slot_chan = '0;
  logic [15:0] slot_last = '0;
  logic eng_done = 0;
  logic sw_start_clr, samp_win, eng_start, store_valid, busy;
  logic [3:0] eng_chan, store_slot, store_chan;

  int n_chk = 0, n_fail = 0, n_store = 0, n_start = 0, n_clr = 0;
  int win_run = 0, last_len = 0, eng_cnt = 0;
  int st_slot [512];
  int st_chan [512];
  int st_win  [512];
  bit finished = 0;

  always #10 clk = ~clk;

  adc_seq_ctrl uut (.*);

  // conversion engine: done three cycles after start
  always @(posedge clk) begin
    if (!rst_n) begin eng_cnt <= 0; eng_done <= 0; end
    else begin
      if (eng_start) eng_cnt <= 3;
      else if (eng_cnt != 0) eng_cnt <= eng_cnt - 1;
      eng_done <= (eng_cnt == 1);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (samp_win) win_run = win_run + 1;
      if (eng_start) begin last_len = win_run; win_run = 0; n_start++; end
      if (sw_start_clr) n_clr++;
      if (store_valid && n_store < 512) begin
        st_slot[n_store] = store_slot;
        st_chan[n_store] = store_chan;
        st_win[n_store]  = samp_win;
        n_store++;
      end
    end
  end

  function automatic int exp_len(int c);
    int k;
    if (c > 12) c = 12;
    if (c < 4) return 4 << c;
    k = c - 4;
    if (k % 2 == 0) return 64 << (k / 2);
    return 96 << ((k - 1) / 2);
  endfunction

  function automatic int chan_of(int s);
    return (s * 5 + 3) % 16;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_src(input int s, input logic v);
    case (s)
      0: sw_start = v;
      1: trig_ta1 = v;
      2: trig_tb0 = v;
      default: trig_tb1 = v;
    endcase
  endtask

  task automatic pulse_src(input int s);
    set_src(s, 1'b1);
    cyc(2);
    set_src(s, 1'b0);
    cyc(1);
  endtask

  task automatic fire();
    pulse_src(int'(trig_sel));
  endtask

  task automatic wait_store(input int target, input int limit);
    int t = 0;
    while (n_store < target && t < limit) begin cyc(1); t++; end
  endtask

  task automatic reidle();
    conv_en = 0;
    cyc(3);
    conv_en = 1;
    cyc(1);
  endtask

  initial begin
    int base;
    for (int i = 0; i < 16; i++) slot_chan[i*4 +: 4] = 4'(chan_of(i));
    cyc(3);
    check(!samp_win && !eng_start && !store_valid && !busy && !sw_start_clr,
          "R13 reset outputs idle", int'({samp_win, eng_start, store_valid, busy}), 0);
    rst_n = 1;
    conv_on = 1; conv_en = 1;
    cyc(2);

    // R4 / R5 / R7: every code, both slot halves, single mode
    for (int c = 0; c < 16; c++) begin
      for (int h = 0; h < 2; h++) begin
        int s;
        s = h * 8 + (c % 8);
        samp_lo_code = 4'(c);
        samp_hi_code = 4'(15 - c);
        start_slot = 4'(s);
        reidle();
        base = n_store;
        fire();
        wait_store(base + 1, 1200);
        check(n_store == base + 1, "R7 one store per edge", n_store - base, 1);
        check(last_len == (h ? exp_len(15 - c) : exp_len(c)), "R4 R5 window length",
              last_len, h ? exp_len(15 - c) : exp_len(c));
        check(st_slot[base] == s, "R7 stored slot", st_slot[base], s);
        check(st_chan[base] == chan_of(s), "R13 stored channel", st_chan[base], chan_of(s));
      end
    end
    check(n_clr == 32, "R2 software start clear pulses", n_clr, 32);

    samp_lo_code = 0; samp_hi_code = 0;

    // R11: chaining has no effect in single mode
    multi_conv = 1; start_slot = 3; reidle();
    base = n_store; fire(); cyc(150);
    check(n_store == base + 1, "R11 multi ignored in mode 00", n_store - base, 1);
    multi_conv = 0;

    // R1: only the selected source starts a conversion
    for (int sel = 0; sel < 4; sel++) begin
      trig_sel = 2'(sel); reidle();
      base = n_store;
      for (int o = 0; o < 4; o++) if (o != sel) pulse_src(o);
      cyc(40);
      check(n_store == base, "R1 unselected sources ignored", n_store - base, 0);
      pulse_src(sel);
      wait_store(base + 1, 100);
      check(n_store == base + 1, "R1 selected source starts", n_store - base, 1);
    end
    trig_sel = 0;

    // R3: enable gating
    conv_en = 0; cyc(2); base = n_store; fire(); cyc(40);
    check(n_store == base, "R3 no conversion with conv_en low", n_store - base, 0);
    conv_en = 1; conv_on = 0; cyc(2); fire(); cyc(40);
    check(n_store == base, "R3 no conversion with conv_on low", n_store - base, 0);
    conv_on = 1; cyc(2); fire(); wait_store(base + 1, 100);
    check(n_store == base + 1, "R3 conversion with both set", n_store - base, 1);

    // R8: list mode, one edge per conversion, wrap 15 -> 0
    seq_mode = 2'b01; start_slot = 14; slot_last = 16'h0202; reidle();
    base = n_store;
    for (int k = 0; k < 5; k++) begin fire(); wait_store(base + k + 1, 100); end
    begin
      int exp8 [5] = '{14, 15, 0, 1, 14};
      for (int k = 0; k < 5; k++)
        check(st_slot[base + k] == exp8[k], "R8 list order", st_slot[base + k], exp8[k]);
    end

    // R11: list mode chained from one edge
    multi_conv = 1; reidle();
    base = n_store; fire(); wait_store(base + 4, 400); cyc(100);
    check(n_store == base + 4, "R11 chained list length", n_store - base, 4);
    begin
      int exp11 [4] = '{14, 15, 0, 1};
      for (int k = 0; k < 4; k++) begin
        check(st_slot[base + k] == exp11[k], "R11 chained order", st_slot[base + k], exp11[k]);
        check(st_win[base + k] == (k < 3), "R11 next window at store", st_win[base + k], k < 3);
      end
    end

    // R6: direct mode, window follows trigger, multi ignored
    pulse_mode = 0; trig_sel = 1; seq_mode = 2'b01; start_slot = 14; reidle();
    base = n_store; trig_ta1 = 1; cyc(20);
    check(samp_win == 1'b1, "R6 window follows trigger high", samp_win, 1);
    check(n_start == n_start && !eng_start && busy, "R6 no start while trigger high", eng_start, 0);
    trig_ta1 = 0; cyc(1);
    check(eng_start == 1'b1, "R6 start one cycle after fall", eng_start, 1);
    check(samp_win == 1'b0, "R6 window low after fall", samp_win, 0);
    cyc(100);
    check(n_store == base + 1, "R6 multi ignored in direct mode", n_store - base, 1);
    pulse_mode = 1; trig_sel = 0;

    // R9 / R12: repeat single slot
    seq_mode = 2'b10; multi_conv = 0; start_slot = 5; reidle();
    base = n_store;
    for (int k = 0; k < 3; k++) begin fire(); wait_store(base + k + 1, 100); end
    for (int k = 0; k < 3; k++)
      check(st_slot[base + k] == 5, "R9 repeated slot", st_slot[base + k], 5);
    multi_conv = 1; reidle();
    base = n_store; fire(); wait_store(base + 3, 400);
    conv_en = 0; cyc(200);
    check(n_store == base + 4, "R12 stop after current conversion", n_store - base, 4);
    check(st_slot[base + 3] == 5, "R9 chained repeat slot", st_slot[base + 3], 5);
    check(busy == 1'b0, "R12 idle after stop", busy, 0);
    conv_en = 1; cyc(1);

    // R10: repeat list, edge per conversion then chained
    seq_mode = 2'b11; multi_conv = 0; start_slot = 2; slot_last = 16'h0212; reidle();
    base = n_store;
    for (int k = 0; k < 4; k++) begin fire(); wait_store(base + k + 1, 100); end
    begin
      int exp10 [4] = '{2, 3, 4, 2};
      for (int k = 0; k < 4; k++)
        check(st_slot[base + k] == exp10[k], "R10 repeat list order", st_slot[base + k], exp10[k]);
    end
    multi_conv = 1; reidle();
    base = n_store; fire(); wait_store(base + 7, 800);
    conv_en = 0; cyc(200);
    check(n_store == base + 8, "R12 repeat list stops", n_store - base, 8);
    begin
      int exp10c [8] = '{2, 3, 4, 2, 3, 4, 2, 3};
      for (int k = 0; k < 8; k++)
        check(st_slot[base + k] == exp10c[k], "R10 chained repeat list", st_slot[base + k], exp10c[k]);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule